// File: doc/BRIEF.md
# Byte-Wide Flash Control and Identifier Logic

This block is a synthesizable behavioral model of the control side of a byte-wide flash memory that is erased as a whole chip. It takes active-low chip, output and write enables, an address bus, a split data bus (input, output and output enable), a programming-voltage flag and a high-voltage identifier flag that sits on one address line. From these it decodes the operating mode. The array is a parameterized register file that resets to the erased state.

Programming can only clear bits. An erase is accepted only after every byte has been driven to zero. Both operations take a parameterized number of clock cycles. During that time `busy` is high, further writes are ignored, and the operation runs to its end even if the chip is deselected. An identifier read returns one of two fixed bytes, selected by address bit 0.

Mode decode (combinational, states of `fb_mode_e`): `M_STANDBY` when `ce_n` is high. Otherwise `M_ID_READ` when `oe_n` and `ce_n` are low, `id_hv` is high and `vpp_hi` is low. Otherwise `M_READ` when `oe_n` is low. Otherwise `M_WRITE` when `we_n` is low and `vpp_hi` is high. Anything else is `M_OUT_DIS`. Sequencer states (`fb_state_e`): `S_IDLE`, `S_PROG` and `S_ERASE`. The transitions are:
- IDLE->PROG on an accepted program write.
- IDLE->ERASE on an accepted erase while the array is all zero.
- IDLE->IDLE with the error flag set on a rejected erase.
- PROG/ERASE->IDLE on the last operation cycle.

Top module: `flash_byte_ctl`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0; while `dq_oe` is 0, `dq_out` is 8'h00.
- R2: While `ce_n` is 1, no write is accepted and `dq_oe` is 0, whatever the other controls are.
- R3: With `ce_n`=0, `oe_n`=0, `id_hv`=1 and `vpp_hi`=0, `dq_out` is 8'h89 when `addr[0]`=0 and 8'hB4 when `addr[0]`=1.
- R4: In any other enabled read, `dq_out` is the stored byte at `addr`. This includes a read with `id_hv`=1 and `vpp_hi`=1.
- R5: After reset every byte reads 8'hFF.
- R6: A write is taken at the clock edge where `we_n` is first sampled 1 after being 0. It is accepted only if, at the last clock edge where `we_n` was sampled 0, `ce_n` was 0, `oe_n` was 1 and `vpp_hi` was 1. Otherwise it is ignored, so that with `vpp_hi` low the part is read-only.
- R7: A program stores the old byte AND the written byte.
- R8: `busy` is 1 for exactly OP_CYCLES cycles, starting with the cycle after the accepting edge. The array changes at the edge that ends `busy`. Writes that arrive while `busy` is 1 are ignored. The operation completes even if `ce_n` goes to 1.
- R9: An accepted write with `id_hv`=1 is an erase request. If every byte is 8'h00, the whole array becomes 8'hFF when the operation ends.
- R10: An erase request while any byte is nonzero starts no operation and leaves the array unchanged. It sets `erase_err` from the next cycle. `erase_err` clears when the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output |
| dq_oe | output | 1 | Data bus drive enable |
| vpp_hi | input | 1 | Programming voltage present |
| id_hv | input | 1 | High-voltage flag on address bit 9 |
| busy | output | 1 | Program or erase in progress |
| erase_err | output | 1 | Last erase request was rejected |

## Verification
`dq_oe` and `dq_out` are combinational, so they are due in the same cycle as the control and address inputs. `busy` and `erase_err` are due one edge after the edge that samples `we_n` high. Array contents change OP_CYCLES edges after the accepting edge. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and all outputs are compared 2 ns after the falling edge, when both the inputs and the registered state have settled. Directed reads add literal expected values at the same sampling point.

// File: rtl/flash_byte_pkg.sv
package flash_byte_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_OUT_DIS,
        M_READ,
        M_ID_READ,
        M_WRITE
    } fb_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PROG,
        S_ERASE
    } fb_state_e;

    localparam logic [7:0] ID_CODE_LO = 8'h89;
    localparam logic [7:0] ID_CODE_HI = 8'hB4;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/flash_byte_decode.sv
module flash_byte_decode
    import flash_byte_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       vpp_hi,
    input  logic       id_hv,
    input  logic       addr0,
    input  logic [7:0] arr_data,
    output fb_mode_e   mode,
    output logic [7:0] dq_out,
    output logic       dq_oe
);

    always_comb begin
        if (ce_n)
            mode = M_STANDBY;
        else if (!oe_n && id_hv && !vpp_hi)
            mode = M_ID_READ;
        else if (!oe_n)
            mode = M_READ;
        else if (!we_n && vpp_hi)
            mode = M_WRITE;
        else
            mode = M_OUT_DIS;
    end

    always_comb begin
        dq_oe  = 1'b0;
        dq_out = 8'h00;
        unique case (mode)
            M_READ: begin
                dq_oe  = 1'b1;
                dq_out = arr_data;
            end
            M_ID_READ: begin
                dq_oe  = 1'b1;
                dq_out = addr0 ? ID_CODE_HI : ID_CODE_LO;
            end
            M_STANDBY, M_OUT_DIS, M_WRITE: begin
                dq_oe  = 1'b0;
                dq_out = 8'h00;
            end
            default: begin
                dq_oe  = 1'b0;
                dq_out = 8'h00;
            end
        endcase
    end

    // R3: identifier reads return only the two fixed codes
    assert_id_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && id_hv && !vpp_hi) |->
            (dq_out == (addr0 ? 8'hB4 : 8'h89)));

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
    import flash_byte_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_we,
    input  logic              erase_we,
    output logic              all_zero
);

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] nonzero;
    logic [7:0]       cur_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (erase_we) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (prog_we) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_nz
        assign nonzero[g] = |mem[g];
    end

    assign all_zero = ~|nonzero;
    assign rd_data  = mem[rd_addr];
    assign cur_byte = mem[wr_addr];

    // R7: a program never turns a 0 bit into a 1
    assert_prog_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> ((mem[$past(wr_addr)] & ~$past(cur_byte)) == 8'h00));

    // R9: an erase is only ever committed over an all-zero array
    assert_erase_needs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_we |-> all_zero);

endmodule

// File: rtl/flash_byte_seq.sv
module flash_byte_seq
    import flash_byte_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int OP_CYCLES  = 8,
    localparam int CNT_W     = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  fb_mode_e          mode,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              all_zero,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              prog_we,
    output logic              erase_we,
    output logic              busy,
    output logic              erase_err
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYCLES - 1);

    fb_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              we_q;
    logic              cap_ok, cap_erase;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;
    logic              we_rise, last, take;

    assign we_rise = !we_q && we_n;
    assign last    = (cnt == LAST);
    assign take    = (state == S_IDLE) && we_rise && cap_ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (take) begin
                    if (!cap_erase)    state_nx = S_PROG;
                    else if (all_zero) state_nx = S_ERASE;
                end
            end
            S_PROG, S_ERASE: begin
                if (last) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx == S_IDLE || state == S_IDLE) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q      <= 1'b1;
            cap_ok    <= 1'b0;
            cap_erase <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
            op_addr   <= '0;
            op_data   <= '0;
            erase_err <= 1'b0;
        end else begin
            we_q <= we_n;
            if (!we_n) begin
                cap_ok    <= (mode == M_WRITE);
                cap_erase <= id_hv;
                cap_addr  <= addr;
                cap_data  <= din;
            end
            if (take) begin
                op_addr   <= cap_addr;
                op_data   <= cap_data;
                erase_err <= cap_erase && !all_zero;
            end
        end
    end

    always_comb begin
        busy     = 1'b0;
        prog_we  = 1'b0;
        erase_we = 1'b0;
        unique case (state)
            S_IDLE:  busy = 1'b0;
            S_PROG: begin
                busy    = 1'b1;
                prog_we = last;
            end
            S_ERASE: begin
                busy     = 1'b1;
                erase_we = last;
            end
            default: busy = 1'b0;
        endcase
    end

    // R8: once started, an operation keeps busy up until its commit cycle
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_we && !erase_we) |=> busy);

    // R8: the captured operand does not move while an operation runs
    assert_operand_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_addr));

    // R10: a rejected erase starts no operation
    assert_reject_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_err) |-> !busy);

endmodule

// File: rtl/flash_byte_ctl.sv
module flash_byte_ctl
    import flash_byte_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int OP_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic              vpp_hi,
    input  logic              id_hv,
    output logic              busy,
    output logic              erase_err
);

    fb_mode_e          mode;
    logic [7:0]        arr_data;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic              prog_we, erase_we, all_zero;

    flash_byte_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .vpp_hi   (vpp_hi),
        .id_hv    (id_hv),
        .addr0    (addr[0]),
        .arr_data (arr_data),
        .mode     (mode),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    flash_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (addr),
        .rd_data  (arr_data),
        .wr_addr  (op_addr),
        .wr_data  (op_data),
        .prog_we  (prog_we),
        .erase_we (erase_we),
        .all_zero (all_zero)
    );

    flash_byte_seq #(.ADDR_W(ADDR_W), .OP_CYCLES(OP_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_n      (we_n),
        .mode      (mode),
        .id_hv     (id_hv),
        .addr      (addr),
        .din       (dq_in),
        .all_zero  (all_zero),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .prog_we   (prog_we),
        .erase_we  (erase_we),
        .busy      (busy),
        .erase_err (erase_err)
    );

    // R2: while deselected the bus is never driven
    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);

endmodule

// File: tb/flash_byte_ctl_tb.sv
`timescale 1ns/1ps
module flash_byte_ctl_tb;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int OPC   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic          vpp_hi = 1'b0, id_hv = 1'b0;
    logic [7:0]    dq_out;
    logic          dq_oe, busy, erase_err;

    int n_run = 0, n_fail = 0, cyc = 0;

    // model state
    logic [7:0]    m_mem [DEPTH];
    int            m_left = 0;
    bit            m_erase_op = 0, m_err = 0, m_we_prev = 1;
    bit            m_cap_ok = 0, m_cap_er = 0;
    logic [AW-1:0] m_cap_a = '0, m_op_a = '0;
    logic [7:0]    m_cap_d = '0, m_op_d = '0;

    always #4 clk = ~clk;   // 125 MHz

    flash_byte_ctl #(.ADDR_W(AW), .OP_CYCLES(OPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .vpp_hi(vpp_hi), .id_hv(id_hv), .busy(busy), .erase_err(erase_err)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic bit m_all_zero();
        for (int i = 0; i < DEPTH; i++) if (m_mem[i] != 8'h00) return 0;
        return 1;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            m_left = 0; m_err = 0; m_we_prev = 1; m_cap_ok = 0;
        end else begin
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_erase_op) for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                    else m_mem[m_op_a] = m_mem[m_op_a] & m_op_d;
                end
            end else if (!m_we_prev && we_n && m_cap_ok) begin
                if (!m_cap_er) begin
                    m_left = OPC; m_erase_op = 0; m_err = 0;
                    m_op_a = m_cap_a; m_op_d = m_cap_d;
                end else if (m_all_zero()) begin
                    m_left = OPC; m_erase_op = 1; m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
            if (!we_n) begin
                m_cap_ok = !ce_n && oe_n && vpp_hi;
                m_cap_er = id_hv;
                m_cap_a  = addr;
                m_cap_d  = dq_in;
            end
            m_we_prev = we_n;
        end
    end

    // per-cycle comparison, 2 ns after the falling edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            bit         e_oe, e_id;
            logic [7:0] e_out;
            e_oe  = !ce_n && !oe_n;
            e_id  = e_oe && id_hv && !vpp_hi;
            e_out = !e_oe ? 8'h00 : e_id ? (addr[0] ? 8'hB4 : 8'h89) : m_mem[addr];
            check("R1 dq_oe", {7'b0, dq_oe}, {7'b0, e_oe});
            check(e_id ? "R3 id" : "R4 data", dq_out, e_out);
            check("R8 busy", {7'b0, busy}, {7'b0, (m_left > 0)});
            check("R10 erase_err", {7'b0, erase_err}, {7'b0, m_err});
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            ce_n = 1; oe_n = 1; we_n = 1; id_hv = 0;
        end
    endtask

    task automatic rd_chk(logic [AW-1:0] a, bit idf, bit vpp, logic [7:0] exp, string tag);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a; id_hv = idf; vpp_hi = vpp;
        #2;
        check(tag, dq_out, exp);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d, bit vpp, bit er, bit cen);
        @(negedge clk);
        ce_n = cen; oe_n = 1; addr = a; dq_in = d; vpp_hi = vpp; id_hv = er; we_n = 0;
        @(negedge clk);
        we_n = 1;
        @(negedge clk);
        ce_n = 1; id_hv = 0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        #1;
        check("R5 reset busy", {7'b0, busy}, 8'h00);
        check("R5 reset err", {7'b0, erase_err}, 8'h00);
        idle(3);
        rst_n = 1;
        idle(2);
        rd_chk(0, 0, 0, 8'hFF, "R5 erased");
        rd_chk(DEPTH - 1, 0, 0, 8'hFF, "R5 erased top");
        rd_chk(0, 1, 0, 8'h89, "R3 id lo");
        rd_chk(1, 1, 0, 8'hB4, "R3 id hi");
        rd_chk(1, 1, 1, 8'hFF, "R4 id ignored with vpp high");
        // R6: write without programming voltage is ignored
        wr(3, 8'h00, 0, 0, 0);
        idle(OPC + 2);
        rd_chk(3, 0, 0, 8'hFF, "R6 read-only");
        // R2: write while deselected is ignored
        wr(3, 8'h00, 1, 0, 1);
        idle(OPC + 2);
        rd_chk(3, 0, 1, 8'hFF, "R2 standby inhibit");
        // R7: program then AND a second pattern in
        wr(3, 8'hA5, 1, 0, 0);
        idle(OPC + 1);
        rd_chk(3, 0, 1, 8'hA5, "R7 first program");
        wr(3, 8'h3C, 1, 0, 0);
        idle(OPC + 1);
        rd_chk(3, 0, 1, 8'h24, "R7 and-merge");
        // R8: second write during busy ignored; deselect while busy
        wr(5, 8'h0F, 1, 0, 0);
        wr(6, 8'h00, 1, 0, 0);
        idle(OPC + 2);
        rd_chk(5, 0, 1, 8'h0F, "R8 completes while deselected");
        rd_chk(6, 0, 1, 8'hFF, "R8 write during busy ignored");
        // R10: erase rejected while bytes are nonzero
        wr(0, 8'h00, 1, 1, 0);
        idle(2);
        check("R10 err set", {7'b0, erase_err}, 8'h01);
        rd_chk(3, 0, 1, 8'h24, "R10 array unchanged");
        // R9: clear every byte, then erase
        for (int i = 0; i < DEPTH; i++) begin
            wr(i[AW-1:0], 8'h00, 1, 0, 0);
            idle(OPC);
        end
        check("R10 err cleared", {7'b0, erase_err}, 8'h00);
        rd_chk(3, 0, 1, 8'h00, "R9 zeroed");
        wr(7, 8'h55, 1, 1, 0);
        idle(OPC + 1);
        rd_chk(3, 0, 1, 8'hFF, "R9 erased");
        rd_chk(DEPTH - 1, 0, 0, 8'hFF, "R9 erased top");
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule